// File: doc/BRIEF.md
# Fabric Configuration Clear Sequencer

This block wipes the previous contents of a programmable fabric before a new configuration is loaded. It owns the fabric's active-low program line and watches the fabric's init status line. A single-cycle start pulse launches a three-phase handshake. First the program line is released and the block waits for init to be high. Then the program line is pulled low and init is polled until it drops. Finally the program line is released again and the block waits for init to rise, which marks the end of the fabric's own initialisation.

Around the handshake the block emits one-cycle pulses that clear the sticky interrupt flags kept elsewhere in the chip. It finishes with a done level or an error level with a two-bit code. A free-running divider, restarted on every phase change, sets both the spacing of the polls and the unit in which the long waits are timed out. At the default settings with a 50 MHz clock this gives 5 µs polls, 100 polls and one-second waits. The init input is brought through a synchroniser before use.

Top module: `cfg_clear_seq`

## Requirements
- R1: After reset the program line is high, busy, done, error and the flag-clear pulse are low, and the error code is 0.
- R2: A start pulse seen while idle releases the program line high and raises busy. If init is already high, the program line is driven low one cycle after start is sampled, without waiting for a rising edge.
- R3: If init is low in the first phase, the block holds the program line high until init is seen high. If init is not high after TMO_TICKS ticks (TICK_DIV cycles each), it stops with error code 2 (timeout) exactly TMO_TICKS*TICK_DIV cycles after start is sampled.
- R4: With the program line low, init is checked once every TICK_DIV cycles, the first check TICK_DIV cycles after the line falls. The first check that finds init low moves the block on.
- R5: If init is still high at all POLL_LIMIT checks, the block stops with error code 1 (I/O error) and the program line high.
- R6: When init is found low, the flag-clear output pulses for one cycle while the program line is still low, and the program line goes high in the next cycle.
- R7: After that the block waits for a rising edge on init. When the edge comes it pulses flag-clear a second time and then returns to idle with done high. A successful run gives exactly two flag-clear pulses.
- R8: If no rising edge on init arrives within TMO_TICKS ticks in the last phase, the block stops with error code 2 (timeout).
- R9: Abort while busy returns the block to idle in the next cycle with the program line high, done low and error code 3 (aborted).
- R10: Start pulses that arrive while busy are ignored: the running handshake continues unchanged.
- R11: Done and error are never high together. Both are cleared, and busy is raised, in the cycle after an accepted start. Error code 0 means no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to begin the clear handshake |
| abort_i | input | 1 | Cancels a running handshake |
| init_i | input | 1 | Fabric init status line, asynchronous |
| prog_n_o | output | 1 | Fabric program line, active low |
| busy_o | output | 1 | Handshake in progress |
| done_o | output | 1 | Last handshake finished successfully |
| err_o | output | 1 | Last handshake ended in error |
| err_code_o | output | 2 | 0 none, 1 I/O error, 2 timeout, 3 aborted |
| flag_clr_o | output | 1 | One-cycle pulse clearing the sticky interrupt flags |

## Verification
The bench builds the block with a divider of 4, a poll limit of 5, a timeout of 20 ticks and two synchroniser stages. This shrinks the poll window to 20 cycles and the long waits to 80 cycles. With these values every init-drop delay from 0 to 22 cycles after the program line falls can be swept. The expected outcome of each delay follows from the tick spacing and the synchroniser latency, so both sides of the last poll are exercised. The same settings make both timeout phases, abort in each phase, and restarts after every kind of ending short enough to run in full.

// File: rtl/cfg_clear_pkg.sv
package cfg_clear_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_WAIT_HI   = 3'd1,
      ST_PULL_LO   = 3'd2,
      ST_ARM       = 3'd3,
      ST_WAIT_RISE = 3'd4,
      ST_FINISH    = 3'd5
   } seq_state_t;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_IO      = 2'd1,
      ERR_TIMEOUT = 2'd2,
      ERR_ABORT   = 2'd3
   } seq_err_t;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfg_clear_tick.sv
// Restartable tick divider: one-cycle tick every DIV cycles after restart.
module cfg_clear_tick #(
   parameter int unsigned DIV = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic tick_o
);

   if (DIV <= 1) begin : g_every_cycle
      logic unused_div1;
      assign unused_div1 = ^{clk, rst_n, restart_i};
      assign tick_o      = 1'b1;
   end else begin : g_divided
      localparam int unsigned W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (restart_i)      cnt_q <= '0;
         else if (cnt_q == LAST)  cnt_q <= '0;
         else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);
   end

endmodule

// File: rtl/cfg_clear_sync.sv
// Synchroniser for the init line plus a rising-edge catcher armed on request.
module cfg_clear_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   input  logic arm_i,
   output logic level_o,
   output logic rise_seen_o
);

   logic prev_q;
   logic seen_q;

   if (STAGES == 0) begin : g_direct
      assign level_o = async_i;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
         end
      end
      assign level_o = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         prev_q <= level_o;
         if (arm_i)                     seen_q <= level_o & ~prev_q;
         else if (level_o && !prev_q)   seen_q <= 1'b1;
      end
   end

   assign rise_seen_o = seen_q;

endmodule

// File: rtl/cfg_clear_count.sv
// Poll / timeout counter with a run-time limit.
module cfg_clear_count #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         inc_i,
   input  logic [W-1:0] limit_i,
   output logic         last_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (inc_i)   cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == (limit_i - W'(1)));

endmodule

// File: rtl/cfg_clear_seq.sv
module cfg_clear_seq
   import cfg_clear_pkg::*;
#(
   parameter int unsigned TICK_DIV    = 250,
   parameter int unsigned POLL_LIMIT  = 100,
   parameter int unsigned TMO_TICKS   = 200000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       abort_i,
   input  logic       init_i,
   output logic       prog_n_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       err_o,
   output logic [1:0] err_code_o,
   output logic       flag_clr_o
);

   localparam int unsigned CNT_MAX = max_of(POLL_LIMIT, TMO_TICKS);
   localparam int unsigned CW      = $clog2(CNT_MAX + 1);

   if (TICK_DIV < 1)   begin : g_bad_div   $error("TICK_DIV must be at least 1");   end
   if (POLL_LIMIT < 1) begin : g_bad_poll  $error("POLL_LIMIT must be at least 1"); end
   if (TMO_TICKS < 1)  begin : g_bad_tmo   $error("TMO_TICKS must be at least 1");  end
   if (SYNC_STAGES > 4) begin : g_bad_sync $error("SYNC_STAGES must be 0 to 4");    end

   seq_state_t state_q, state_d;
   seq_err_t   err_q, err_d;
   logic       done_q, done_d;

   logic          tick;
   logic          phase_change;
   logic          init_s;
   logic          rise_seen;
   logic          cnt_last;
   logic [CW-1:0] limit;

   assign phase_change = (state_d != state_q);
   assign limit = (state_q == ST_PULL_LO) ? CW'(POLL_LIMIT) : CW'(TMO_TICKS);

   cfg_clear_tick #(.DIV(TICK_DIV)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (phase_change),
      .tick_o    (tick)
   );

   cfg_clear_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .async_i     (init_i),
      .arm_i       (state_q == ST_ARM),
      .level_o     (init_s),
      .rise_seen_o (rise_seen)
   );

   cfg_clear_count #(.W(CW)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (phase_change),
      .inc_i   (tick),
      .limit_i (limit),
      .last_o  (cnt_last)
   );

   always_comb begin
      state_d = state_q;
      err_d   = err_q;
      done_d  = done_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_WAIT_HI;
               err_d   = ERR_NONE;
               done_d  = 1'b0;
            end
         end
         ST_WAIT_HI: begin
            if (init_s) begin
               state_d = ST_PULL_LO;
            end else if (tick && cnt_last) begin
               state_d = ST_IDLE;
               err_d   = ERR_TIMEOUT;
            end
         end
         ST_PULL_LO: begin
            if (tick) begin
               if (!init_s) begin
                  state_d = ST_ARM;
               end else if (cnt_last) begin
                  state_d = ST_IDLE;
                  err_d   = ERR_IO;
               end
            end
         end
         ST_ARM: state_d = ST_WAIT_RISE;
         ST_WAIT_RISE: begin
            if (rise_seen) begin
               state_d = ST_FINISH;
            end else if (tick && cnt_last) begin
               state_d = ST_IDLE;
               err_d   = ERR_TIMEOUT;
            end
         end
         ST_FINISH: begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
      if (abort_i && state_q != ST_IDLE) begin
         state_d = ST_IDLE;
         err_d   = ERR_ABORT;
         done_d  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         err_q   <= ERR_NONE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= err_d;
         done_q  <= done_d;
      end
   end

   assign prog_n_o   = !(state_q == ST_PULL_LO || state_q == ST_ARM);
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign err_o      = (err_q != ERR_NONE);
   assign err_code_o = err_q;
   assign flag_clr_o = (state_q == ST_ARM) || (state_q == ST_FINISH);

endmodule

// File: rtl/cfg_clear_seq_chk.sv
module cfg_clear_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       abort_i,
   input logic       init_i,
   input logic       prog_n_o,
   input logic       busy_o,
   input logic       done_o,
   input logic       err_o,
   input logic [1:0] err_code_o,
   input logic       flag_clr_o
);

   logic unused_chk;
   assign unused_chk = init_i;

   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R11

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !done_o && !err_o)); // R11

   AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i && busy_o) |=> (!busy_o && prog_n_o && !done_o && err_code_o == 2'd3)); // R9

   AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr_o |=> !flag_clr_o); // R6

   AST_CLR_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_o && !prog_n_o) |=> prog_n_o); // R6

   AST_PROG_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n_o |-> busy_o); // R2

   AST_IDLE_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !flag_clr_o); // R7

   AST_DONE_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(flag_clr_o)); // R7

   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !prog_n_o && !flag_clr_o && start_i && !abort_i) |=> (!prog_n_o || err_o)); // R10

endmodule

bind cfg_clear_seq cfg_clear_seq_chk u_chk (.*);

// File: tb/cfg_clear_seq_bench.sv
module cfg_clear_seq_bench;

   localparam int T  = 4;
   localparam int P  = 5;
   localparam int TM = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic abort_i = 1'b0;
   logic init_i = 1'b0;
   logic prog_n_o, busy_o, done_o, err_o, flag_clr_o;
   logic [1:0] err_code_o;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int clr_cnt = 0;
   logic first_prog = 1'b1;
   logic after_prog = 1'b0;
   logic pend = 1'b0;

   int r_lat, r_len, r_done, r_code;
   int s_busy, s_done, s_err;

   always #10 clk = ~clk;

   cfg_clear_seq #(.TICK_DIV(T), .POLL_LIMIT(P), .TMO_TICKS(TM), .SYNC_STAGES(2)) u_cfg_clear_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i), .init_i(init_i),
      .prog_n_o(prog_n_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .err_code_o(err_code_o), .flag_clr_o(flag_clr_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (pend) begin
         after_prog = prog_n_o;
         pend = 1'b0;
      end
      if (flag_clr_o) begin
         if (clr_cnt == 0) begin
            first_prog = prog_n_o;
            pend = 1'b1;
         end
         clr_cnt++;
      end
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_seq(input bit init0, input int hi_d, input int lo_d, input int up_d);
      int t0;
      init_i = init0;
      repeat (3) @(negedge clk);
      clr_cnt = 0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      t0 = cyc;
      s_busy = busy_o; s_done = done_o; s_err = err_o;
      if (!init0 && hi_d >= 0) begin
         repeat (hi_d) @(negedge clk);
         init_i = 1'b1;
      end
      while (busy_o && prog_n_o) @(negedge clk);
      r_lat = busy_o ? cyc - t0 : -1;
      if (busy_o) begin
         if (lo_d >= 0) begin
            repeat (lo_d) @(negedge clk);
            init_i = 1'b0;
         end
         while (busy_o && !prog_n_o) @(negedge clk);
         if (busy_o && up_d >= 0) begin
            repeat (up_d) @(negedge clk);
            init_i = 1'b1;
         end
      end
      while (busy_o) @(negedge clk);
      r_len = cyc - t0;
      r_done = done_o;
      r_code = err_code_o;
   endtask

   task automatic abort_in(input int phase);
      init_i = (phase != 0);
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (phase == 0) begin
         repeat (3) @(negedge clk);
      end else begin
         while (busy_o && prog_n_o) @(negedge clk);
         if (phase == 2) begin
            init_i = 1'b0;
            while (busy_o && !prog_n_o) @(negedge clk);
         end
         repeat (2) @(negedge clk);
      end
      check(busy_o == 1'b1, "R9", "busy before abort", busy_o, 1);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      check(busy_o == 1'b0 && prog_n_o == 1'b1 && done_o == 1'b0, "R9", "idle and released after abort",
            {busy_o, prog_n_o, done_o}, 3'b010);
      check(err_code_o == 2'd3 && err_o, "R9", "abort code", err_code_o, 3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(prog_n_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0 && err_o == 1'b0 &&
            err_code_o == 2'd0 && flag_clr_o == 1'b0, "R1", "outputs in reset",
            {prog_n_o, busy_o, done_o, err_o, err_code_o, flag_clr_o}, 7'b1000000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(prog_n_o == 1'b1 && busy_o == 1'b0 && err_code_o == 2'd0, "R1", "idle after reset",
            {prog_n_o, busy_o, err_code_o}, 4'b1000);

      // R2 / R7: init already high, fabric answers promptly
      run_seq(1'b1, -1, 2, 2);
      check(r_lat == 1, "R2", "program low latency with init high", r_lat, 1);
      check(r_done == 1 && r_code == 0, "R7", "done after rise", r_done, 1);
      check(clr_cnt == 2, "R7", "flag-clear pulse count", clr_cnt, 2);
      check(first_prog == 1'b0, "R6", "first clear while program low", first_prog, 0);
      check(after_prog == 1'b1, "R6", "program high after first clear", after_prog, 1);
      check(s_busy == 1 && s_done == 0 && s_err == 0, "R11", "state after start", s_busy, 1);

      // R3: init low at start, rises later
      run_seq(1'b0, 10, 2, 3);
      check(r_lat >= 10, "R3", "waited for init high", r_lat, 10);
      check(r_done == 1 && r_code == 0, "R3", "completion after late init", r_code, 0);

      // R3: init never high
      run_seq(1'b0, -1, -1, -1);
      check(r_code == 2 && r_done == 0, "R3", "first-phase timeout code", r_code, 2);
      check(r_len == TM * T, "R3", "first-phase timeout length", r_len, TM * T);

      // R11: restart after an error clears error
      run_seq(1'b1, -1, 1, 1);
      check(s_busy == 1 && s_err == 0 && s_done == 0, "R11", "error cleared by start", s_err, 0);
      check(r_done == 1 && r_code == 0, "R11", "clean run after error", r_code, 0);

      // R4 / R5: sweep of init-drop delay across the whole poll window
      for (int d = 0; d <= P * T + 2; d++) begin
         bit ok;
         ok = (d <= P * T - 3);
         run_seq(1'b1, -1, d, 2);
         if (ok) begin
            check(r_done == 1 && r_code == 0, "R4", $sformatf("drop delay %0d accepted", d), r_code, 0);
         end else begin
            check(r_done == 0 && r_code == 1, "R5", $sformatf("drop delay %0d io error", d), r_code, 1);
            check(prog_n_o == 1'b1, "R5", "program released after io error", prog_n_o, 1);
         end
      end
      run_seq(1'b1, -1, -1, -1);
      check(r_code == 1, "R5", "init stuck high io error", r_code, 1);

      // R8: no rising edge in the last phase
      run_seq(1'b1, -1, 1, -1);
      check(r_code == 2 && r_done == 0, "R8", "last-phase timeout code", r_code, 2);
      check(clr_cnt == 1, "R8", "single clear before timeout", clr_cnt, 1);

      // R9: abort in each busy phase
      for (int ph = 0; ph < 3; ph++) abort_in(ph);

      // R10: start pulse during the low phase is ignored
      init_i = 1'b1;
      repeat (3) @(negedge clk);
      clr_cnt = 0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (busy_o && prog_n_o) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      check(prog_n_o == 1'b0 && busy_o == 1'b1, "R10", "program stays low after busy start",
            prog_n_o, 0);
      init_i = 1'b0;
      while (busy_o && !prog_n_o) @(negedge clk);
      repeat (2) @(negedge clk);
      init_i = 1'b1;
      while (busy_o) @(negedge clk);
      check(done_o == 1'b1 && clr_cnt == 2, "R10", "run completes unchanged", clr_cnt, 2);
      check(!(done_o && err_o), "R11", "done and error exclusive", err_o, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule